// File: doc/BRIEF.md
# Channel Fault Interrupt Collector

This block gathers fault requests from a group of output-switch channels into one interrupt towards a host bus. Each channel request is a level that stays high while its fault exists. An enable bit for each channel masks it. A live summary bit is high whenever any unmasked channel is requesting. A master enable lets that summary raise the host request. Once raised, the host request is held even if the fault that caused it goes away without help.

Software drops the held request by clearing the master enable. It arms the path again by setting the master enable back to one. If a masked-in fault is still present at that moment, the request comes back on the next clock.

A small byte-wide register port, synchronous to the block clock, gives access to the enable mask, the control/status byte and three read-only identification bytes. Writes to the identification bytes are accepted and have no effect.

Top module: `irq_collector`

## Requirements
- R1: After reset the enable mask (offset 0x78) reads 0x00, the control byte (offset 0x79) reads 0x00, and `host_irq_o` is low.
- R2: Offset 0x78 is read/write, and bit i enables channel i. It can be changed at any time, including while a request is pending. Setting an enable bit on a channel that is already requesting counts as a new summary assertion.
- R3: In the control byte, bit 6 is the summary: the OR of `chan_req_i & enable`, taken in the cycle of the read strobe. Bit 7 reads back the master enable. All other bits read 0 and ignore writes.
- R4: If the summary and the master enable are both 1 in a cycle (and that cycle does not clear the master enable), `host_irq_o` is 1 in the next cycle.
- R5: While the master enable stays 1, `host_irq_o` stays 1 once it has been raised, even after the summary returns to 0.
- R6: Writing 0 to control bit 7 makes `host_irq_o` low from the cycle after the write, and it stays low for as long as the master enable is 0.
- R7: After the master enable is written back to 1, a summary that is still high raises `host_irq_o` one clock later. A summary that is low leaves it low.
- R8: Offsets 0x7B, 0x7D and 0x7F read the hardware revision (default 0x02), the software revision (default 0x01) and the identification code 0xE3. Writes to these offsets do not change what is read back.
- R9: Reads of any other offset return 0x00. Writes to any other offset change neither a register nor `host_irq_o`.
- R10: Read data appears on `reg_rdata_o` in the cycle after the read strobe. In a cycle that does not follow a read strobe, `reg_rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| chan_req_i | input | NCH (8) | Fault request levels, one for each channel |
| reg_addr_i | input | 7 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| host_irq_o | output | 1 | Latched interrupt request to the host bus |

## Verification
The checker watches several rules on every clock:
- the request rises the cycle after the summary and master enable are both high;
- a raised request holds until software clears the master enable, and a clearing write drops it the next cycle;
- every rising edge of the request has a qualifying cause in the previous cycle;
- identification and unmapped reads return their fixed values;
- idle read data is zero.

Only the bench scenarios can show the following: the per-channel masking and its change while a fault is pending; the exact summary bit under different request patterns; the re-arm order after a clear; and the fact that writes to read-only and unmapped offsets leave the other registers untouched.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;

  localparam int CTRL_MIE_BIT = 7;
  localparam int CTRL_SUM_BIT = 6;

  localparam logic [ADDR_W-1:0] OFS_EN    = 7'h78;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 7'h79;
  localparam logic [ADDR_W-1:0] OFS_HWREV = 7'h7B;
  localparam logic [ADDR_W-1:0] OFS_SWREV = 7'h7D;
  localparam logic [ADDR_W-1:0] OFS_ID    = 7'h7F;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN,
    SEL_CTRL,
    SEL_HWREV,
    SEL_SWREV,
    SEL_ID
  } sel_e;

  function automatic sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    sel_e s;
    case (a)
      OFS_EN:    s = SEL_EN;
      OFS_CTRL:  s = SEL_CTRL;
      OFS_HWREV: s = SEL_HWREV;
      OFS_SWREV: s = SEL_SWREV;
      OFS_ID:    s = SEL_ID;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_image(input logic mie, input logic sum);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CTRL_MIE_BIT] = mie;
    v[CTRL_SUM_BIT] = sum;
    return v;
  endfunction

endpackage

// File: rtl/irq_mask_sum.sv
module irq_mask_sum #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] masked_o,
  output logic           sum_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign masked_o[g] = req_i[g] & en_i[g];
  end

  assign sum_o = |masked_o;

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mie_we_i,
  input  logic mie_wval_i,
  input  logic sum_i,
  output logic mie_o,
  output logic irq_o
);

  logic mie_q;
  logic held_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mie_q <= 1'b0;
    end else if (mie_we_i) begin
      mie_q <= mie_wval_i;
    end
  end

  // Sticky request: set by the summary while armed, wiped while disarmed.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
    end else if (!mie_q) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_q | sum_i;
    end
  end

  assign mie_o = mie_q;
  assign irq_o = held_q & mie_q;

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_collector_pkg::*;
#(
  parameter int                NCH     = 8,
  parameter logic [DATA_W-1:0] HW_REV  = 8'h02,
  parameter logic [DATA_W-1:0] SW_REV  = 8'h01,
  parameter logic [DATA_W-1:0] ID_CODE = 8'hE3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mie_i,
  input  logic              sum_i,
  output logic [NCH-1:0]    en_o,
  output logic              mie_we_o,
  output logic              mie_wval_o,
  output logic [DATA_W-1:0] rdata_o
);

  sel_e              sel;
  logic [NCH-1:0]    en_q;
  logic [DATA_W-1:0] en_image;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign sel = decode_ofs(addr_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (wr_i && sel == SEL_EN) begin
      en_q <= wdata_i[NCH-1:0];
    end
  end

  assign mie_we_o   = wr_i && sel == SEL_CTRL;
  assign mie_wval_o = wdata_i[CTRL_MIE_BIT];

  always_comb begin
    en_image = '0;
    en_image[NCH-1:0] = en_q;
  end

  always_comb begin
    case (sel)
      SEL_EN:    rd_mux = en_image;
      SEL_CTRL:  rd_mux = ctrl_image(mie_i, sum_i);
      SEL_HWREV: rd_mux = HW_REV;
      SEL_SWREV: rd_mux = SW_REV;
      SEL_ID:    rd_mux = ID_CODE;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_i ? rd_mux : '0;
    end
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_collector_pkg::*;
#(
  parameter int                NCH     = 8,
  parameter logic [DATA_W-1:0] HW_REV  = 8'h02,
  parameter logic [DATA_W-1:0] SW_REV  = 8'h01,
  parameter logic [DATA_W-1:0] ID_CODE = 8'hE3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    chan_req_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              host_irq_o
);

  logic [NCH-1:0] chan_en;
  logic [NCH-1:0] chan_masked;
  logic           sum_req;
  logic           mie_q;
  logic           mie_we;
  logic           mie_wval;
  logic           mie_clr_ev;
  logic           mie_set_ev;

  irq_mask_sum #(.NCH(NCH)) u_mask (
    .req_i    (chan_req_i),
    .en_i     (chan_en),
    .masked_o (chan_masked),
    .sum_o    (sum_req)
  );

  irq_regfile #(
    .NCH     (NCH),
    .HW_REV  (HW_REV),
    .SW_REV  (SW_REV),
    .ID_CODE (ID_CODE)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .wdata_i    (reg_wdata_i),
    .mie_i      (mie_q),
    .sum_i      (sum_req),
    .en_o       (chan_en),
    .mie_we_o   (mie_we),
    .mie_wval_o (mie_wval),
    .rdata_o    (reg_rdata_o)
  );

  irq_req_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mie_we_i   (mie_we),
    .mie_wval_i (mie_wval),
    .sum_i      (sum_req),
    .mie_o      (mie_q),
    .irq_o      (host_irq_o)
  );

  // Named events for the checker.
  assign mie_clr_ev = mie_we & ~mie_wval;
  assign mie_set_ev = mie_we &  mie_wval;

endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk
  import irq_collector_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_CODE = 8'hE3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_rd_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              host_irq_o,
  input logic              sum_req,
  input logic              mie_q,
  input logic              mie_clr_ev
);

  // R4
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_req && mie_q && !mie_clr_ev) |=> host_irq_o);

  // R4
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_irq_o) |-> $past(sum_req && mie_q));

  // R5
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_irq_o && !mie_clr_ev) |=> host_irq_o);

  // R6
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mie_clr_ev |=> !host_irq_o);

  // R8
  id_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == OFS_ID) |=> reg_rdata_o == ID_CODE);

  // R9
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && decode_ofs(reg_addr_i) == SEL_NONE) |=> reg_rdata_o == '0);

  // R10
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> reg_rdata_o == '0);

endmodule

bind irq_collector irq_collector_chk #(.ID_CODE(ID_CODE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_rdata_o (reg_rdata_o),
  .host_irq_o  (host_irq_o),
  .sum_req     (sum_req),
  .mie_q       (mie_q),
  .mie_clr_ev  (mie_clr_ev)
);

// File: tb/irq_collector_bench.sv
`timescale 1ns/1ps
module irq_collector_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic [6:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic rd_seen = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  irq_collector u_irq_collector (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .chan_req_i  (req),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .host_irq_o  (irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // Driver: issues a read and pushes the expected byte for the monitor.
  task automatic rd_reg(input logic [6:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic irq_is(input logic e, input string tag);
    chk(tag, {7'b0, irq}, {7'b0, e});
  endtask

  always @(posedge clk) rd_seen <= rst_n & rd;

  // Monitor: pops one expected byte per completed read; idle cycles must read 0 (R10).
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_seen) begin
        if (exp_q.size() == 0) begin
          chk("R10 unexpected read", rdata, 8'hxx);
        end else begin
          chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end else begin
        chk("R10 idle rdata", rdata, 8'h00);
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    irq_is(1'b0, "R1 irq after reset");
    rd_reg(7'h78, 8'h00, "R1 enable mask after reset");
    rd_reg(7'h79, 8'h00, "R1 control after reset");

    wr_reg(7'h78, 8'hA5);
    rd_reg(7'h78, 8'hA5, "R2 enable readback");
    wr_reg(7'h78, 8'h00);
    rd_reg(7'h78, 8'h00, "R2 enable cleared");

    req = 8'h01;
    rd_reg(7'h79, 8'h00, "R3 summary masked");
    wr_reg(7'h78, 8'h01);
    rd_reg(7'h79, 8'h40, "R3 summary set");
    irq_is(1'b0, "R6 low while mie 0");

    wr_reg(7'h79, 8'h80);
    irq_is(1'b0, "R7 not yet raised");
    @(negedge clk);
    irq_is(1'b1, "R7 raised one clock after arm");
    rd_reg(7'h79, 8'hC0, "R3 mie and summary");

    req = 8'h00;
    rd_reg(7'h79, 8'h80, "R3 summary self-cleared");
    irq_is(1'b1, "R5 request held");
    repeat (3) @(negedge clk);
    irq_is(1'b1, "R5 request still held");

    wr_reg(7'h79, 8'h00);
    irq_is(1'b0, "R6 dropped by mie clear");
    rd_reg(7'h79, 8'h00, "R6 control cleared");

    wr_reg(7'h79, 8'h80);
    repeat (2) @(negedge clk);
    irq_is(1'b0, "R7 rearm without source");

    req = 8'h10;
    repeat (2) @(negedge clk);
    irq_is(1'b0, "R2 masked channel ignored");
    wr_reg(7'h78, 8'h11);
    @(negedge clk);
    irq_is(1'b1, "R2 enable while pending raises");

    wr_reg(7'h79, 8'hFF);
    rd_reg(7'h79, 8'hC0, "R3 other control bits read 0");

    rd_reg(7'h7B, 8'h02, "R8 hw revision");
    rd_reg(7'h7D, 8'h01, "R8 sw revision");
    rd_reg(7'h7F, 8'hE3, "R8 id code");
    wr_reg(7'h7B, 8'hFF);
    wr_reg(7'h7D, 8'h55);
    wr_reg(7'h7F, 8'h00);
    rd_reg(7'h7B, 8'h02, "R8 hw revision after write");
    rd_reg(7'h7D, 8'h01, "R8 sw revision after write");
    rd_reg(7'h7F, 8'hE3, "R8 id code after write");

    rd_reg(7'h00, 8'h00, "R9 unmapped 0x00");
    rd_reg(7'h7A, 8'h00, "R9 unmapped 0x7A");
    rd_reg(7'h7E, 8'h00, "R9 unmapped 0x7E");
    wr_reg(7'h00, 8'hFF);
    wr_reg(7'h7A, 8'h00);
    wr_reg(7'h7C, 8'h00);
    rd_reg(7'h78, 8'h11, "R9 enable untouched");
    rd_reg(7'h79, 8'hC0, "R9 control untouched");
    irq_is(1'b1, "R9 irq untouched");

    repeat (3) @(negedge clk);
    chk("R10 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule